// File: doc/BRIEF.md
# Preemptive Fixed-Priority Bus Grant Arbiter

This block decides which of several bus masters may drive a shared, PCI-style bus. Each master pulls its own active-low request line. The arbiter answers by pulling exactly one active-low grant line. Priority is fixed: master 0 wins over master 1, and master 1 wins over master 2. A grant is not permanent. It is taken back when a more important master starts requesting, when the holder drops its request, or when the holder lets a fixed window of clocks pass without starting a transfer. Every removal is followed by one clock with no grant at all, so two masters never see a grant in back-to-back cycles.

A master shows that its transfer has started by pulling the shared start strobe low during a cycle in which its grant is low. From then on it owns the bus until the bus-idle flag goes high. A higher-priority request that arrives during that transfer removes the grant line, but it does not cut the transfer short. The next grant waits until the bus is idle. No master is parked on the bus: with no requests pending, every grant line stays high. Requests, start and idle status are plain level signals sampled on each rising clock edge. There is no data path, so the block has no valid/ready interface.

Top module: `bus_grant_arbiter`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, every bit of gnt_n is 1.
- R2: At most one bit of gnt_n is 0 in any cycle. gnt_n[i] low means master i owns the bus.
- R3: When no grant is held and no blank cycle is in progress, a low req_n sampled at a clock edge makes gnt_n low for the requester with the lowest index, starting in the cycle that follows that edge.
- R4: If every req_n bit and every gnt_n bit were 1 in the previous cycle, every gnt_n bit is 1 in this cycle.
- R5: If a master is granted and has not yet pulled start_n low, and a master with a lower index pulls its req_n low, the grant is removed in the cycle after that request is sampled.
- R6: In any cycle in which a gnt_n bit returns to 1, all gnt_n bits are 1. The next grant can appear one cycle later at the earliest.
- R7: A grant that sees no low start_n is held for exactly TIMEOUT cycles (16 by default) and then removed. A start_n low in any of those cycles, the last one included, keeps the grant.
- R8: Once start_n has been sampled low while a grant is held, no other master is granted until bus_idle is sampled high. The owner's line goes high, and stays high for the rest of the transfer, if a lower-index request is sampled during it.
- R9: If the granted master raises its req_n before pulling start_n low, its grant is removed in the next cycle.
- R10: A master that timed out and still holds req_n low takes part in the next arbitration like any other master. If it is the only requester, it is granted again after the single blank cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_n | input | N | Active-low request, one bit per master, bit 0 highest priority |
| start_n | input | 1 | Active-low strobe: the granted master begins a transfer |
| bus_idle | input | 1 | High when no transfer is in progress on the bus |
| gnt_n | output | N | Active-low grant, one bit per master, at most one low |

## Verification
The bound checker checks four things on every clock. Grants stay one-hot-or-none. A grant line that releases always lands in an all-high cycle. Any fresh grant goes to the requester that had priority in the previous cycle. No other master is granted while a started transfer is open. It also counts grant cycles that pass without a start, which bounds the timeout. The exact cycle of each removal cannot be seen by those properties alone: preemption latency, timeout at exactly sixteen cycles, a start in the final cycle of the window, and re-grant of a timed-out master. These are shown by the bench's scenarios, with a clock-by-clock reference model that predicts every grant line.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Arbiter sequencing states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // nobody granted, arbitration open
    ST_OWNED = 2'd1,  // grant driven, waiting for start strobe
    ST_BUSY  = 2'd2,  // transfer started, waiting for bus idle
    ST_GAP   = 2'd3   // one blank cycle after a removal
  } arb_state_e;

endpackage

// File: rtl/arb_prio_pick.sv
// Fixed-priority selector: bit 0 wins. Also reports whether any requester
// ranked above the current owner is pending.
module arb_prio_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,        // active-high requests
  input  logic [N-1:0] owner_oh,   // current owner, one-hot or zero
  output logic [N-1:0] win_oh,     // highest-priority requester
  output logic         req_any,
  output logic         higher_pending,
  output logic         owner_req
);

  logic [N-1:0] above;  // above[i]: some j < i is requesting

  for (genvar i = 0; i < N; i++) begin : g_rank
    if (i == 0) begin : g_top
      assign above[i]  = 1'b0;
      assign win_oh[i] = req[i];
    end else begin : g_rest
      assign above[i]  = |req[i-1:0];
      assign win_oh[i] = req[i] & ~(|req[i-1:0]);
    end
  end

  assign req_any        = |req;
  assign higher_pending = |(above & owner_oh);
  assign owner_req      = |(req & owner_oh);

endmodule

// File: rtl/arb_slot_timer.sv
// Counts cycles a grant has been held without a start strobe.
module arb_slot_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (run && cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/arb_ctrl.sv
// Grant sequencer: idle -> owned -> (busy) -> gap -> arbitrate again.
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_any,
  input  logic [N-1:0] win_oh,
  input  logic         higher_pending,
  input  logic         owner_req,
  input  logic         start,
  input  logic         bus_idle,
  input  logic         expired,
  output arb_state_e   state,
  output logic [N-1:0] owner_oh,
  output logic         revoked,
  output logic         timer_clear,
  output logic         timer_run
);

  arb_state_e   state_q, state_d;
  logic [N-1:0] owner_q, owner_d;
  logic         rev_q, rev_d;

  always_comb begin
    state_d     = state_q;
    owner_d     = owner_q;
    rev_d       = rev_q;
    timer_clear = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_GAP: begin
        if (req_any) begin
          state_d     = ST_OWNED;
          owner_d     = win_oh;
          timer_clear = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_OWNED: begin
        if (start) begin
          state_d = ST_BUSY;
          rev_d   = 1'b0;
        end else if (higher_pending || !owner_req || expired) begin
          state_d = ST_GAP;
        end
      end
      ST_BUSY: begin
        if (higher_pending) begin
          rev_d = 1'b1;
        end
        if (bus_idle) begin
          state_d = ST_GAP;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      owner_q <= '0;
      rev_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      owner_q <= owner_d;
      rev_q   <= rev_d;
    end
  end

  assign state     = state_q;
  assign owner_oh  = owner_q;
  assign revoked   = rev_q;
  assign timer_run = (state_q == ST_OWNED);

endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter
  import arb_pkg::*;
#(
  parameter int N       = 3,
  parameter int TIMEOUT = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_n,
  input  logic         start_n,
  input  logic         bus_idle,
  output logic [N-1:0] gnt_n
);

  logic [N-1:0] req;
  logic [N-1:0] win_oh;
  logic [N-1:0] owner_oh;
  logic         req_any, higher_pending, owner_req;
  logic         expired, timer_clear, timer_run, revoked;
  logic         drive;
  arb_state_e   state;

  assign req = ~req_n;

  arb_prio_pick #(.N(N)) u_pick (
    .req            (req),
    .owner_oh       (owner_oh),
    .win_oh         (win_oh),
    .req_any        (req_any),
    .higher_pending (higher_pending),
    .owner_req      (owner_req)
  );

  arb_slot_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (timer_clear),
    .run     (timer_run),
    .expired (expired)
  );

  arb_ctrl #(.N(N)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_any        (req_any),
    .win_oh         (win_oh),
    .higher_pending (higher_pending),
    .owner_req      (owner_req),
    .start          (~start_n),
    .bus_idle       (bus_idle),
    .expired        (expired),
    .state          (state),
    .owner_oh       (owner_oh),
    .revoked        (revoked),
    .timer_clear    (timer_clear),
    .timer_run      (timer_run)
  );

  assign drive = (state == ST_OWNED) || (state == ST_BUSY && !revoked);
  assign gnt_n = ~(owner_oh & {N{drive}});

endmodule

// File: rtl/bus_grant_arbiter_chk.sv
module bus_grant_arbiter_chk #(
  parameter int N       = 3,
  parameter int TIMEOUT = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req_n,
  input logic         start_n,
  input logic         bus_idle,
  input logic [N-1:0] gnt_n
);

  localparam int TW = $clog2(TIMEOUT + 1);

  logic [N-1:0]  req_prev, gnt_prev, busy_gnt;
  logic [N-1:0]  prev_req_hi, prev_win, fresh;
  logic [TW-1:0] held_cnt;
  logic          seen_start, busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_prev   <= '1;
      gnt_prev   <= '1;
      held_cnt   <= '0;
      seen_start <= 1'b0;
      busy_q     <= 1'b0;
      busy_gnt   <= '1;
    end else begin
      req_prev <= req_n;
      gnt_prev <= gnt_n;
      if (&gnt_n) begin
        held_cnt   <= '0;
        seen_start <= 1'b0;
      end else begin
        if (held_cnt != TW'(TIMEOUT)) held_cnt <= held_cnt + 1'b1;
        if (!start_n) seen_start <= 1'b1;
      end
      if (busy_q) begin
        if (bus_idle) busy_q <= 1'b0;
      end else if (!start_n && !(&gnt_n)) begin
        busy_q   <= 1'b1;
        busy_gnt <= gnt_n;
      end
    end
  end

  assign prev_req_hi = ~req_prev;
  assign prev_win    = prev_req_hi & (~prev_req_hi + 1'b1);
  assign fresh       = ~gnt_n & gnt_prev;

  // R2: never more than one grant low
  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  // R6: a released grant lands in an all-high cycle
  a_r6_blank_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gnt_n & ~gnt_prev)) |-> (&gnt_n));

  // R3: a new grant goes to last cycle's highest-priority requester
  a_r3_fresh_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (|fresh) |-> (~gnt_n == prev_win));

  // R4: no requests and no grant stays no grant
  a_r4_no_parking: assert property (@(posedge clk) disable iff (!rst_n)
    ((&req_prev) && (&gnt_prev)) |-> (&gnt_n));

  // R7: a grant without a start never exceeds the window
  a_r7_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&gnt_n) && !seen_start) |-> (int'(held_cnt) < TIMEOUT));

  // R8: during a started transfer no other master is granted
  a_r8_transfer_kept: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ((gnt_n == busy_gnt) || (&gnt_n)));

endmodule

bind bus_grant_arbiter bus_grant_arbiter_chk #(.N(N), .TIMEOUT(TIMEOUT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_n    (req_n),
  .start_n  (start_n),
  .bus_idle (bus_idle),
  .gnt_n    (gnt_n)
);

// File: tb/test_bus_grant_arbiter.sv
module test_bus_grant_arbiter;
  localparam int N   = 3;
  localparam int TMO = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req_n;
  logic         start_n;
  logic         bus_idle;
  logic [N-1:0] gnt_n;

  int    vectors = 0;
  int    miscompares = 0;
  string tag = "R1";
  bit    done = 0;

  // behavioural model: 0 idle, 1 owned, 2 transfer, 3 blank
  int m_state, m_owner, m_timer, m_w;
  bit m_rev;

  always #5 clk = ~clk;

  bus_grant_arbiter #(.N(N), .TIMEOUT(TMO)) i_bus_grant_arbiter (
    .clk(clk), .rst_n(rst_n), .req_n(req_n),
    .start_n(start_n), .bus_idle(bus_idle), .gnt_n(gnt_n)
  );

  function automatic int pick(logic [N-1:0] r);
    for (int i = 0; i < N; i++) if (!r[i]) return i;
    return -1;
  endfunction

  function automatic bit outranked(int o, logic [N-1:0] r);
    for (int j = 0; j < o; j++) if (!r[j]) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_owner = 0; m_timer = 0; m_rev = 0;
    end else begin
      case (m_state)
        0, 3: begin
          m_w = pick(req_n);
          if (m_w >= 0) begin m_state = 1; m_owner = m_w; m_timer = 0; end
          else m_state = 0;
        end
        1: begin
          if (!start_n) begin m_state = 2; m_rev = 0; end
          else if (outranked(m_owner, req_n) || req_n[m_owner] || m_timer == TMO - 1)
            m_state = 3;
          else m_timer++;
        end
        default: begin
          if (outranked(m_owner, req_n)) m_rev = 1;
          if (bus_idle) m_state = 3;
        end
      endcase
    end
  end

  function automatic logic [N-1:0] expect_gnt();
    logic [N-1:0] e = '1;
    if (m_state == 1 || (m_state == 2 && !m_rev)) e[m_owner] = 1'b0;
    return e;
  endfunction

  task automatic check_cycle();
    logic [N-1:0] e = expect_gnt();
    vectors++;
    if (gnt_n !== e) begin
      miscompares++;
      $display("FAIL %s t=%0t gnt_n=%b expected %b", tag, $time, gnt_n, e);
    end
    vectors++;
    if ($countones(~gnt_n) > 1) begin
      miscompares++;
      $display("FAIL R2 t=%0t gnt_n=%b expected at most one low", $time, gnt_n);
    end
  endtask

  task automatic tick(int n, string t);
    tag = t;
    repeat (n) begin
      @(negedge clk);
      check_cycle();
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL all-reqs watchdog gnt_n=%b expected run finished", gnt_n);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_n = '1; start_n = 1'b1; bus_idle = 1'b1;
    tick(3, "R1");
    rst_n = 1'b1;
    tick(1, "R1");
    tick(4, "R4");                        // no requests: nothing parked

    // R3: lone request from master 2, transfer, release at idle
    req_n = 3'b011;
    tick(2, "R3");
    start_n = 1'b0; bus_idle = 1'b0;
    tick(1, "R8");
    start_n = 1'b1; req_n = 3'b111;
    tick(3, "R8");
    bus_idle = 1'b1;
    tick(3, "R6");

    // R3: masters 1 and 2 together, master 1 wins
    req_n = 3'b001;
    tick(2, "R3");
    start_n = 1'b0; bus_idle = 1'b0;
    tick(1, "R8");
    start_n = 1'b1; req_n = 3'b011;
    tick(4, "R8");
    bus_idle = 1'b1;
    tick(1, "R6");
    tick(1, "R6");                        // master 2 granted after blank

    // R5: master 0 preempts master 2 before it starts
    req_n = 3'b010;
    tick(1, "R5");
    tick(2, "R6");
    start_n = 1'b0; bus_idle = 1'b0;
    tick(1, "R8");
    start_n = 1'b1; req_n = 3'b111;
    tick(2, "R8");
    bus_idle = 1'b1;
    tick(3, "R4");

    // R7 / R10: master 1 times out, keeps requesting, is granted again
    req_n = 3'b101;
    tick(18, "R7");
    tick(4, "R10");
    // R9: master 1 gives up its request before starting
    req_n = 3'b111;
    tick(3, "R9");

    // R7: start in the final cycle of the window keeps the grant
    req_n = 3'b110;
    tick(TMO, "R7");
    start_n = 1'b0; bus_idle = 1'b0;
    tick(1, "R7");
    start_n = 1'b1; req_n = 3'b111;
    tick(3, "R7");
    bus_idle = 1'b1;
    tick(2, "R7");

    // R8: higher request during a transfer drops the line, waits for idle
    req_n = 3'b011;
    tick(2, "R8");
    start_n = 1'b0; bus_idle = 1'b0;
    tick(1, "R8");
    start_n = 1'b1; req_n = 3'b010;
    tick(5, "R8");
    bus_idle = 1'b1;
    tick(3, "R8");
    req_n = 3'b111;
    tick(3, "R9");
    tick(3, "R4");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule